// File: doc/BRIEF.md
# Decode-Stage Branch Resolution and Fetch Control

This block owns the program counter and the fetch-to-decode pipeline register of a five-stage in-order pipeline. It decides in the decode stage whether a conditional branch is taken. The block compares the two forwarded operands of an equal-compare branch and adds the scaled immediate to the sequential PC of the branch. Because of this, a taken branch redirects the very next fetch and costs a single cycle rather than waiting for the execute or memory stage.

The instruction memory is external. The block presents the fetch address, receives the fetched word in the same cycle and latches it, together with its sequential PC, into the decode register. Register read and forwarding are external as well. The block exposes the decode-stage instruction so the register file can be read, and it takes the two operand values back. A hazard unit can freeze fetch and decode with a stall input.

A build-time parameter selects the control-hazard policy. In squash mode, fetch runs ahead at PC+4 and the single wrong-path word is replaced by a zero no-op when the branch resolves taken. In delay-slot mode, the word after the branch always proceeds, and the target is fetched right after it.

Top module: `fetchBranchUnit`

## Requirements
- R1: While reset is held and right after it, `fetchPc` equals `RESET_PC`, `decInstr` and `decPcPlus4` are zero, and `branchTaken` and `flushIfId` are low.
- R2: With stall low and no taken branch, `fetchPc` advances by 4 every cycle. The decode register captures the fetched word and its address plus 4.
- R3: A decode-stage word is a taken branch only when bits 31:26 equal 6'b000100 and the two operands (read from register fields 25:21 and 20:16) are equal. Any other opcode, or unequal operands, never redirects fetch.
- R4: The branch target is the decode-stage PC+4 plus the 16-bit immediate in bits 15:0, sign-extended from bit 15 and shifted left by 2. Negative immediates give backward targets.
- R5: A taken branch in decode makes the next cycle's `fetchPc` equal to the target, which is a one-cycle penalty.
- R6: In squash mode (`DELAY_SLOT`=0) a taken branch asserts `flushIfId`. The following decode word and its PC+4 are all zero.
- R7: In delay-slot mode (`DELAY_SLOT`=1) `flushIfId` never asserts. The word fetched right after the branch enters decode, and the target is fetched in the same cycle.
- R8: While `stall` is high, `fetchPc`, `decInstr` and `decPcPlus4` hold, `branchTaken` and `flushIfId` stay low, and `nextPc` equals `fetchPc`.
- R9: A branch held in decode by a stall is resolved in the first cycle after the stall clears.
- R10: When not stalled, `nextPc` is the value `fetchPc` takes after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Hazard-unit freeze of PC and decode register |
| fetchInstr | input | ILEN | Word read from instruction memory at `fetchPc` |
| rsVal | input | XLEN | Forwarded value of the first source register of the decode word |
| rtVal | input | XLEN | Forwarded value of the second source register of the decode word |
| fetchPc | output | XLEN | Current fetch address |
| nextPc | output | XLEN | Fetch address for the next cycle |
| decInstr | output | ILEN | Instruction word held in the decode register |
| decPcPlus4 | output | XLEN | Sequential PC of the decode-stage word |
| branchTaken | output | 1 | Decode-stage branch resolved taken this cycle |
| flushIfId | output | 1 | Wrong-path fetch is being discarded this cycle |

## Verification
The bench runs both policies side by side against a cycle model and targets the wrong-path slot, a backward branch, a stall that lands on a branch in decode, and a branch-like opcode with equal operands. A design that failed to squash would let the word after the branch reach decode in squash mode. One that squashed in delay-slot mode would lose the slot word. A missing sign extension sends the backward branch far forward, and resolving during a stall redirects fetch while the PC should be frozen. Decoding the wrong opcode field would take the look-alike branch.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int OPC_W = 6;
  localparam int IMM_W = 16;
  localparam int OPC_LSB = 26;
  localparam logic [OPC_W-1:0] OPC_BEQ = 6'b000100;

  typedef struct packed {
    logic hold;      // freeze PC and decode register
    logic redirect;  // load branch target into PC
    logic squash;    // replace decode register with no-op
  } fetchStrobe_t;
endpackage

// File: rtl/fetchCtrl.sv
module fetchCtrl
  import fetch_pkg::*;
#(
  parameter int DELAY_SLOT = 0
) (
  input  logic [OPC_W-1:0] decOpcode,
  input  logic             operandsEqual,
  input  logic             stall,
  output fetchStrobe_t     strobe,
  output logic             branchTaken,
  output logic             flushIfId
);
  logic isBranch;
  logic resolved;
  logic squashSel;

  assign isBranch = (decOpcode == OPC_BEQ);
  assign resolved = isBranch & operandsEqual & ~stall;

  generate
    if (DELAY_SLOT != 0) begin : g_slot
      assign squashSel = 1'b0;
    end else begin : g_squash
      assign squashSel = resolved;
    end
  endgenerate

  always_comb begin
    strobe          = '0;
    strobe.hold     = stall;
    strobe.redirect = resolved;
    strobe.squash   = squashSel;
  end

  assign branchTaken = resolved;
  assign flushIfId   = squashSel;
endmodule

// File: rtl/fetchPath.sv
module fetchPath
  import fetch_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ILEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  fetchStrobe_t     strobe,
  input  logic [ILEN-1:0]  fetchInstr,
  input  logic [XLEN-1:0]  rsVal,
  input  logic [XLEN-1:0]  rtVal,
  output logic [XLEN-1:0]  fetchPc,
  output logic [XLEN-1:0]  nextPc,
  output logic [ILEN-1:0]  decInstr,
  output logic [XLEN-1:0]  decPcPlus4,
  output logic [OPC_W-1:0] decOpcode,
  output logic             operandsEqual
);
  localparam int SIGN_W = XLEN - IMM_W;
  localparam int WORD_SHIFT = 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pcQ;
  logic [ILEN-1:0] irQ;
  logic [XLEN-1:0] pc4Q;
  logic [XLEN-1:0] seqPc;
  logic [XLEN-1:0] immExt;
  logic [XLEN-1:0] branchTarget;

  assign seqPc        = pcQ + STEP;
  assign immExt       = {{SIGN_W{irQ[IMM_W-1]}}, irQ[IMM_W-1:0]};
  assign branchTarget = pc4Q + (immExt << WORD_SHIFT);
  assign operandsEqual = (rsVal == rtVal);
  assign decOpcode    = irQ[OPC_LSB +: OPC_W];

  always_comb begin
    if (strobe.hold)          nextPc = pcQ;
    else if (strobe.redirect) nextPc = branchTarget;
    else                      nextPc = seqPc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ  <= RESET_PC;
      irQ  <= '0;
      pc4Q <= '0;
    end else if (!strobe.hold) begin
      pcQ <= nextPc;
      if (strobe.squash) begin
        irQ  <= '0;
        pc4Q <= '0;
      end else begin
        irQ  <= fetchInstr;
        pc4Q <= seqPc;
      end
    end
  end

  assign fetchPc    = pcQ;
  assign decInstr   = irQ;
  assign decPcPlus4 = pc4Q;
endmodule

// File: rtl/fetchBranchUnit.sv
module fetchBranchUnit
  import fetch_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ILEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter int DELAY_SLOT = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            stall,
  input  logic [ILEN-1:0] fetchInstr,
  input  logic [XLEN-1:0] rsVal,
  input  logic [XLEN-1:0] rtVal,
  output logic [XLEN-1:0] fetchPc,
  output logic [XLEN-1:0] nextPc,
  output logic [ILEN-1:0] decInstr,
  output logic [XLEN-1:0] decPcPlus4,
  output logic            branchTaken,
  output logic            flushIfId
);
  fetchStrobe_t     strobe;
  logic [OPC_W-1:0] decOpcode;
  logic             operandsEqual;

  fetchCtrl #(.DELAY_SLOT(DELAY_SLOT)) u_ctrl (
    .decOpcode    (decOpcode),
    .operandsEqual(operandsEqual),
    .stall        (stall),
    .strobe       (strobe),
    .branchTaken  (branchTaken),
    .flushIfId    (flushIfId)
  );

  fetchPath #(.XLEN(XLEN), .ILEN(ILEN), .RESET_PC(RESET_PC)) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .fetchInstr   (fetchInstr),
    .rsVal        (rsVal),
    .rtVal        (rtVal),
    .fetchPc      (fetchPc),
    .nextPc       (nextPc),
    .decInstr     (decInstr),
    .decPcPlus4   (decPcPlus4),
    .decOpcode    (decOpcode),
    .operandsEqual(operandsEqual)
  );
endmodule

// File: rtl/fetchBranchUnit_chk.sv
module fetchBranchUnit_chk #(
  parameter int XLEN = 32,
  parameter int ILEN = 32,
  parameter int DELAY_SLOT = 0
) (
  input logic            clk,
  input logic            rstN,
  input logic            stall,
  input logic [ILEN-1:0] fetchInstr,
  input logic [XLEN-1:0] rsVal,
  input logic [XLEN-1:0] rtVal,
  input logic [XLEN-1:0] fetchPc,
  input logic [XLEN-1:0] nextPc,
  input logic [ILEN-1:0] decInstr,
  input logic [XLEN-1:0] decPcPlus4,
  input logic            branchTaken,
  input logic            flushIfId
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !branchTaken) |=> fetchPc == $past(fetchPc) + STEP);

  p_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !flushIfId) |=> decInstr == $past(fetchInstr));

  p_taken_beq_r3: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> (decInstr[ILEN-1 -: 6] == 6'b000100 && rsVal == rtVal));

  p_squash_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    flushIfId |=> (decInstr == '0 && decPcPlus4 == '0));

  p_flush_policy_r7: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> (flushIfId == (DELAY_SLOT == 0)));

  p_flush_needs_taken_r6: assert property (@(posedge clk) disable iff (!rstN)
    flushIfId |-> branchTaken);

  p_slot_enters_r7: assert property (@(posedge clk) disable iff (!rstN)
    (branchTaken && DELAY_SLOT != 0) |=> decPcPlus4 == $past(fetchPc) + STEP);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (fetchPc == $past(fetchPc) && decInstr == $past(decInstr)
               && decPcPlus4 == $past(decPcPlus4)));

  p_stall_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (!branchTaken && !flushIfId && nextPc == fetchPc));

  p_next_pc_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stall |=> fetchPc == $past(nextPc));
endmodule

bind fetchBranchUnit fetchBranchUnit_chk #(
  .XLEN(XLEN), .ILEN(ILEN), .DELAY_SLOT(DELAY_SLOT)
) u_chk (
  .clk(clk), .rstN(rstN), .stall(stall), .fetchInstr(fetchInstr),
  .rsVal(rsVal), .rtVal(rtVal), .fetchPc(fetchPc), .nextPc(nextPc),
  .decInstr(decInstr), .decPcPlus4(decPcPlus4),
  .branchTaken(branchTaken), .flushIfId(flushIfId)
);

// File: tb/tb_fetchBranchUnit.sv
`timescale 1ns/1ps
module tb_fetchBranchUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stall = 1'b0;
  int   prog = 0;
  int   nTests = 0;
  int   nFail = 0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [31:0] beqWord(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [15:0] imm);
    return {6'b000100, rs, rt, imm};
  endfunction

  function automatic logic [31:0] imem(input int p, input logic [31:0] a);
    logic [31:0] w;
    w = {6'b001000, 10'h0, a[15:0]};
    case (p)
      0: if (a == 32'h4)  w = beqWord(5'd2, 5'd3, 16'd3);
      1: if (a == 32'h4)  w = beqWord(5'd2, 5'd4, 16'd3);
      2: if (a == 32'h10) w = beqWord(5'd6, 5'd7, 16'hFFFC);
      3: if (a == 32'h4)  w = {6'b000101, 5'd2, 5'd3, 16'd3};
      default: ;
    endcase
    return w;
  endfunction

  // register file stand-in: pairs (2,3), (4,5), (6,7) read equal values
  function automatic logic [31:0] rf(input logic [4:0] i);
    return {28'h0, i[4:1]};
  endfunction

  logic [31:0] pcA, npA, irA, p4A, pcB, npB, irB, p4B;
  logic        tkA, flA, tkB, flB;

  fetchBranchUnit #(.DELAY_SLOT(0)) dut (
    .clk(clk), .rstN(rstN), .stall(stall),
    .fetchInstr(imem(prog, pcA)), .rsVal(rf(irA[25:21])), .rtVal(rf(irA[20:16])),
    .fetchPc(pcA), .nextPc(npA), .decInstr(irA), .decPcPlus4(p4A),
    .branchTaken(tkA), .flushIfId(flA));

  fetchBranchUnit #(.DELAY_SLOT(1)) dutSlot (
    .clk(clk), .rstN(rstN), .stall(stall),
    .fetchInstr(imem(prog, pcB)), .rsVal(rf(irB[25:21])), .rtVal(rf(irB[20:16])),
    .fetchPc(pcB), .nextPc(npB), .decInstr(irB), .decPcPlus4(p4B),
    .branchTaken(tkB), .flushIfId(flB));

  // reference state per policy: index 0 squash, 1 delay slot
  logic [31:0] mPc [2];
  logic [31:0] mIr [2];
  logic [31:0] mP4 [2];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int m = 0; m < 2; m++) begin
      mPc[m] = 32'h0; mIr[m] = 32'h0; mP4[m] = 32'h0;
    end
  endtask

  // one clock: drive stall, compare both instances to the model, advance
  task automatic doCycle(input bit st);
    logic [31:0] oPc, oNp, oIr, oP4, tgt, nPc, nIr, nP4;
    logic        oTk, oFl, expTk;
    stall = st;
    #1;
    for (int m = 0; m < 2; m++) begin
      oPc = (m == 0) ? pcA : pcB;  oNp = (m == 0) ? npA : npB;
      oIr = (m == 0) ? irA : irB;  oP4 = (m == 0) ? p4A : p4B;
      oTk = (m == 0) ? tkA : tkB;  oFl = (m == 0) ? flA : flB;
      expTk = (mIr[m][31:26] == 6'b000100) &&
              (rf(mIr[m][25:21]) == rf(mIr[m][20:16])) && !st;
      tgt = mP4[m] + ({{16{mIr[m][15]}}, mIr[m][15:0]} << 2);
      nPc = st ? mPc[m] : (expTk ? tgt : mPc[m] + 32'd4);
      if (st) begin
        nIr = mIr[m]; nP4 = mP4[m];
      end else if (expTk && m == 0) begin
        nIr = 32'h0; nP4 = 32'h0;
      end else begin
        nIr = imem(prog, mPc[m]); nP4 = mPc[m] + 32'd4;
      end
      check("R2", "fetchPc", oPc, mPc[m]);
      check("R2", "decInstr", oIr, mIr[m]);
      check("R2", "decPcPlus4", oP4, mP4[m]);
      check("R3", "branchTaken", {31'h0, oTk}, {31'h0, expTk});
      check(m == 0 ? "R6" : "R7", "flushIfId", {31'h0, oFl},
            {31'h0, expTk && m == 0});
      check("R10", "nextPc", oNp, nPc);
      mPc[m] = nPc; mIr[m] = nIr; mP4[m] = nP4;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic applyReset(input int p);
    @(negedge clk);
    rstN = 1'b0; stall = 1'b0; prog = p;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
    #1;
    check("R1", "reset fetchPc", pcA, 32'h0);
    check("R1", "reset decInstr", irA, 32'h0);
    check("R1", "reset slot decPcPlus4", p4B, 32'h0);
    check("R1", "reset taken/flush", {30'h0, tkA, flA}, 32'h0);
  endtask

  task automatic tForwardTaken();
    applyReset(0);
    for (int i = 0; i < 3; i++) doCycle(1'b0);
    check("R5", "squash redirect pc", pcA, 32'h14);
    check("R6", "squashed decode word", irA, 32'h0);
    check("R4", "slot target pc", pcB, 32'h14);
    check("R7", "slot word in decode", irB, imem(0, 32'h8));
    doCycle(1'b0);
    check("R7", "target word after slot", irB, imem(0, 32'h14));
    for (int i = 0; i < 3; i++) doCycle(1'b0);
  endtask

  task automatic tNotTaken();
    applyReset(1);
    for (int i = 0; i < 3; i++) doCycle(1'b0);
    check("R3", "unequal operands fall through", pcA, 32'hC);
    check("R3", "fall-through word kept", irA, imem(1, 32'h8));
    for (int i = 0; i < 3; i++) doCycle(1'b0);
  endtask

  task automatic tBackward();
    applyReset(2);
    for (int i = 0; i < 6; i++) doCycle(1'b0);
    check("R4", "backward target squash", pcA, 32'h4);
    check("R4", "backward target slot", pcB, 32'h4);
    for (int i = 0; i < 8; i++) doCycle(1'b0);
  endtask

  task automatic tOtherOpcode();
    applyReset(3);
    for (int i = 0; i < 3; i++) doCycle(1'b0);
    check("R3", "non-beq opcode ignored", pcA, 32'hC);
    check("R3", "non-beq opcode ignored slot", pcB, 32'hC);
    doCycle(1'b0);
  endtask

  task automatic tStallOnBranch();
    applyReset(0);
    doCycle(1'b0);
    doCycle(1'b0);
    doCycle(1'b1);
    doCycle(1'b1);
    check("R8", "pc frozen under stall", pcA, 32'h8);
    check("R8", "branch held in decode", irA, beqWord(5'd2, 5'd3, 16'd3));
    doCycle(1'b0);
    check("R9", "branch resolves after stall", pcA, 32'h14);
    check("R9", "slot kept after stall", irB, imem(0, 32'h8));
    doCycle(1'b1);
    doCycle(1'b0);
  endtask

  task automatic tMixedStalls();
    applyReset(2);
    for (int i = 0; i < 40; i++) doCycle((i % 3) == 1 || (i % 7) == 5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    tForwardTaken();
    tNotTaken();
    tBackward();
    tOtherOpcode();
    tStallOnBranch();
    tMixedStalls();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule